// File: doc/BRIEF.md
# Control and Status Register Block

This block gives software a small set of control and status registers over a plain byte-addressed bus: an address, a write strobe with write data, and a read strobe whose data returns one cycle later with a valid flag. Each register bundles a different kind of field. One field is stored and drives hardware, one is a live view of a hardware input, one can be loaded from either side, and one counts hardware events. The last is a sticky event bit that a software read clears. A bank of identical scratch registers sits at a fixed stride higher in the address space.

The bus never stalls. A write takes effect at the clock edge where `bus_wr` is sampled high. A read is accepted at every clock edge where `bus_rd` is high, and the data appears on `bus_rdata` with `bus_rvalid` in the following cycle. There is no back-pressure and no handshake. The master must not issue a read and a write in the same cycle to different targets, because there is only one address. Hardware-side pins are plain level or pulse signals.

Top module: `csr_regblock`

## Requirements
- R1: After reset, CTRL at offset 0x000 reads 0x0000013A, SHARED at 0x008 reads 42 (0x2A), and STAT at 0x004 reads the live input. The counter at 0x00C, the event flag at 0x010 and every array entry read 0. The control outputs come out of reset as mode=0xA, gain=0x3, enable=1 and arm=0.
- R2: CTRL holds four software read/write fields: mode [3:0], gain [7:4], enable [8] and arm [16]. A write updates all four, and their stored values drive `ctl_mode`, `ctl_gain`, `ctl_en` and `ctl_arm` continuously. All other bits read 0.
- R3: STAT (0x004) has no storage. A read returns `stat_in` as sampled in the read-request cycle, zero-extended, and writes to STAT have no effect.
- R4: SHARED (0x008, bits [7:0]) is written by software, except in a cycle where `shr_we` is high, when it loads `shr_in` and the software write of that cycle is lost. Its value drives `shr_q`.
- R5: The counter at 0x00C (bits [7:0]) is read-only. It adds one for each cycle in which software reads or writes SHARED, and it wraps from 0xFF to 0x00. Writes to it have no effect.
- R6: The event flag at 0x010 (bit 0) is set by an `evt_set` pulse and cleared by a software read of 0x010. That read returns the value before clearing. If `evt_set` and the read fall in the same cycle, the flag stays set. Writes and reads of other addresses leave it unchanged.
- R7: Sixteen 16-bit read/write entries sit at 0x1000 + 0x10*n for n = 0..15. Each entry is stored independently, and upper bits read 0.
- R8: Any other address, including the addresses between array entries and 0x1100 and above, reads as all zeros, and a write to it changes no register.
- R9: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high. `bus_rdata` carries the read result then and is all zeros whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address relative to block base |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| ctl_mode | output | 4 | CTRL mode field |
| ctl_gain | output | 4 | CTRL gain field |
| ctl_en | output | 1 | CTRL enable field |
| ctl_arm | output | 1 | CTRL arm field |
| stat_in | input | 8 | Live status value seen through STAT |
| shr_we | input | 1 | Hardware write enable for SHARED |
| shr_in | input | 8 | Hardware value for SHARED |
| shr_q | output | 8 | Current SHARED value |
| evt_set | input | 1 | Event flag set pulse |

## Verification
On every cycle, the assertions check several properties. The counter steps by exactly one per SHARED access and holds otherwise. The event flag obeys set-over-clear. The hardware load of SHARED wins, a CTRL write reaches the outputs, STAT reads mirror the input, and unmapped reads and idle cycles return zeros. A write to one array entry leaves the other entries stable. The bench scenarios cover the rest: the reset values, the exact stride decode of all sixteen entries and the holes between them, wrap-around after 256 accesses, the value a same-cycle read and set returns, and that writes to read-only registers leave their readback unchanged.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int OFF_CTRL   = 'h000;
  localparam int OFF_STAT   = 'h004;
  localparam int OFF_SHARED = 'h008;
  localparam int OFF_CNT    = 'h00C;
  localparam int OFF_EVT    = 'h010;

  localparam int MODE_W   = 4;
  localparam int GAIN_W   = 4;
  localparam int MODE_LSB = 0;
  localparam int GAIN_LSB = MODE_LSB + MODE_W;
  localparam int EN_BIT   = GAIN_LSB + GAIN_W;
  localparam int ARM_BIT  = 16;

  localparam logic [MODE_W-1:0] MODE_RST = 4'hA;
  localparam logic [GAIN_W-1:0] GAIN_RST = 4'h3;
  localparam logic              EN_RST   = 1'b1;
  localparam logic              ARM_RST  = 1'b0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_SHARED,
    SEL_CNT,
    SEL_EVT,
    SEL_ARR
  } csr_sel_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ARR_BASE   = 'h1000,
  parameter int ARR_N      = 16,
  parameter int ARR_STRIDE = 'h10,
  localparam int IDX_W     = (ARR_N > 1) ? $clog2(ARR_N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);

  localparam int STRIDE_LG = $clog2(ARR_STRIDE);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ARR_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(ARR_N * ARR_STRIDE);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(ARR_STRIDE - 1);

  logic [ADDR_W-1:0] off;
  logic              in_arr;

  always_comb begin
    off    = addr - BASE_A;
    in_arr = (addr >= BASE_A) && (off < SPAN_A) && ((off & MASK_A) == '0);
    idx    = IDX_W'(off >> STRIDE_LG);
    if (in_arr) begin
      sel = SEL_ARR;
    end else begin
      case (addr)
        ADDR_W'(OFF_CTRL):   sel = SEL_CTRL;
        ADDR_W'(OFF_STAT):   sel = SEL_STAT;
        ADDR_W'(OFF_SHARED): sel = SEL_SHARED;
        ADDR_W'(OFF_CNT):    sel = SEL_CNT;
        ADDR_W'(OFF_EVT):    sel = SEL_EVT;
        default:             sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R5: one step per access, wrapping
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/csr_event.sv
module csr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rclr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (rclr) flag <= 1'b0;
  end

  // R6: hardware set has precedence over read-clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rclr && !set) |=> !flag);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rclr && !set) |=> $stable(flag));

endmodule

// File: rtl/csr_array.sv
module csr_array #(
  parameter int ARR_N     = 16,
  parameter int ARR_W     = 16,
  localparam int IDX_W    = (ARR_N > 1) ? $clog2(ARR_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARR_W-1:0] wdata,
  output logic [ARR_W-1:0] rdata
);

  logic [ARR_W-1:0] entry [ARR_N];

  for (genvar g = 0; g < ARR_N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             entry[g] <= '0;
      else if (we && idx == IDX_W'(g))        entry[g] <= wdata;
    end

    // R7: entries are independent
    assert_entry_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && idx == IDX_W'(g)) |=> $stable(entry[g]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < ARR_N; i++) begin
      if (idx == IDX_W'(i)) rdata = entry[i];
    end
  end

endmodule

// File: rtl/csr_regblock.sv
module csr_regblock
  import csr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int STAT_W     = 8,
  parameter int SHR_W      = 8,
  parameter int SHR_RST    = 42,
  parameter int CNT_W      = 8,
  parameter int ARR_N      = 16,
  parameter int ARR_W      = 16,
  parameter int ARR_BASE   = 'h1000,
  parameter int ARR_STRIDE = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [MODE_W-1:0] ctl_mode,
  output logic [GAIN_W-1:0] ctl_gain,
  output logic              ctl_en,
  output logic              ctl_arm,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              shr_we,
  input  logic [SHR_W-1:0]  shr_in,
  output logic [SHR_W-1:0]  shr_q,
  input  logic              evt_set
);

  localparam int IDX_W = (ARR_N > 1) ? $clog2(ARR_N) : 1;

  csr_sel_e         sel;
  logic [IDX_W-1:0] arr_idx;
  logic [CNT_W-1:0] acc_cnt;
  logic             evt_flag;
  logic [ARR_W-1:0] arr_rdata;
  logic [DATA_W-1:0] rd_mux;
  logic             shr_acc;
  logic             evt_rclr;
  logic             arr_we;

  csr_decode #(
    .ADDR_W(ADDR_W), .ARR_BASE(ARR_BASE), .ARR_N(ARR_N), .ARR_STRIDE(ARR_STRIDE)
  ) u_decode (
    .addr(bus_addr), .sel(sel), .idx(arr_idx)
  );

  // CTRL: software-owned fields driving hardware
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_mode <= MODE_RST;
      ctl_gain <= GAIN_RST;
      ctl_en   <= EN_RST;
      ctl_arm  <= ARM_RST;
    end else if (bus_wr && sel == SEL_CTRL) begin
      ctl_mode <= bus_wdata[MODE_LSB +: MODE_W];
      ctl_gain <= bus_wdata[GAIN_LSB +: GAIN_W];
      ctl_en   <= bus_wdata[EN_BIT];
      ctl_arm  <= bus_wdata[ARM_BIT];
    end
  end

  // SHARED: hardware load has priority over software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          shr_q <= SHR_W'(SHR_RST);
    else if (shr_we)                     shr_q <= shr_in;
    else if (bus_wr && sel == SEL_SHARED) shr_q <= bus_wdata[SHR_W-1:0];
  end

  assign shr_acc  = (bus_wr || bus_rd) && (sel == SEL_SHARED);
  assign evt_rclr = bus_rd && (sel == SEL_EVT);
  assign arr_we   = bus_wr && (sel == SEL_ARR);

  csr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .inc(shr_acc), .cnt(acc_cnt)
  );

  csr_event u_event (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .rclr(evt_rclr), .flag(evt_flag)
  );

  csr_array #(.ARR_N(ARR_N), .ARR_W(ARR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .idx(arr_idx),
    .wdata(bus_wdata[ARR_W-1:0]), .rdata(arr_rdata)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[MODE_LSB +: MODE_W] = ctl_mode;
        rd_mux[GAIN_LSB +: GAIN_W] = ctl_gain;
        rd_mux[EN_BIT]             = ctl_en;
        rd_mux[ARM_BIT]            = ctl_arm;
      end
      SEL_STAT:   rd_mux = DATA_W'(stat_in);
      SEL_SHARED: rd_mux = DATA_W'(shr_q);
      SEL_CNT:    rd_mux = DATA_W'(acc_cnt);
      SEL_EVT:    rd_mux = DATA_W'(evt_flag);
      SEL_ARR:    rd_mux = DATA_W'(arr_rdata);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  // R2: a CTRL write reaches the hardware outputs
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CTRL) |=>
      (ctl_mode == $past(bus_wdata[MODE_LSB +: MODE_W]) && ctl_arm == $past(bus_wdata[ARM_BIT])));
  // R3: STAT reads mirror the input
  assert_stat_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_STAT) |=> bus_rdata == DATA_W'($past(stat_in)));
  // R4: hardware write enable wins
  assert_hw_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shr_we |=> shr_q == $past(shr_in));
  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);
  // R9: read latency and idle data
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == '0);

endmodule

// File: tb/csr_regblock_bench.sv
module csr_regblock_bench;

  localparam logic [15:0] A_CTRL = 16'h0000;
  localparam logic [15:0] A_STAT = 16'h0004;
  localparam logic [15:0] A_SHR  = 16'h0008;
  localparam logic [15:0] A_CNT  = 16'h000C;
  localparam logic [15:0] A_EVT  = 16'h0010;
  localparam logic [15:0] A_ARR  = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  ctl_mode;
  logic [3:0]  ctl_gain;
  logic        ctl_en;
  logic        ctl_arm;
  logic [7:0]  stat_in = '0;
  logic        shr_we = 1'b0;
  logic [7:0]  shr_in = '0;
  logic [7:0]  shr_q;
  logic        evt_set = 1'b0;

  int n_vec  = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  csr_regblock u_csr_regblock (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ctl_mode(ctl_mode), .ctl_gain(ctl_gain),
    .ctl_en(ctl_en), .ctl_arm(ctl_arm), .stat_in(stat_in), .shr_we(shr_we),
    .shr_in(shr_in), .shr_q(shr_q), .evt_set(evt_set)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [31:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: compare each returned read against the scoreboard (R9 timing)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    check("watchdog", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    stat_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 ctl_mode", 32'(ctl_mode), 32'hA);
    check("R1 ctl_gain", 32'(ctl_gain), 32'h3);
    check("R1 ctl_en",   32'(ctl_en),   32'h1);
    check("R1 ctl_arm",  32'(ctl_arm),  32'h0);
    check("R9 idle rvalid", 32'(bus_rvalid), 32'h0);
    check("R9 idle rdata", bus_rdata, 32'h0);
    rd(A_CTRL, 32'h0000013A, "R1 CTRL reset");
    rd(A_SHR,  32'h0000002A, "R1 SHARED reset");
    rd(A_EVT,  32'h0, "R1 EVENT reset");
    rd(A_ARR + 16'h50, 32'h0, "R1 array reset");
    rd(A_STAT, 32'h3C, "R1 STAT live");
    rd(A_CNT,  32'h1, "R5 count after one SHARED read");

    // R2 CTRL fields
    wr(A_CTRL, 32'hFFFF_FFFF);
    check("R2 mode", 32'(ctl_mode), 32'hF);
    check("R2 gain", 32'(ctl_gain), 32'hF);
    check("R2 en",   32'(ctl_en),   32'h1);
    check("R2 arm",  32'(ctl_arm),  32'h1);
    rd(A_CTRL, 32'h000101FF, "R2 CTRL all ones");
    wr(A_CTRL, 32'h0001_0025);
    check("R2 mode2", 32'(ctl_mode), 32'h5);
    check("R2 gain2", 32'(ctl_gain), 32'h2);
    check("R2 en2",   32'(ctl_en),   32'h0);
    rd(A_CTRL, 32'h00010025, "R2 CTRL pattern");

    // R3 STAT live, writes ignored
    stat_in = 8'h5C;
    rd(A_STAT, 32'h5C, "R3 STAT read");
    wr(A_STAT, 32'hFFFF_FFFF);
    stat_in = 8'hA7;
    rd(A_STAT, 32'hA7, "R3 STAT after write");

    // R4 SHARED
    wr(A_SHR, 32'hFFFF_FF77);
    check("R4 shr_q sw write", 32'(shr_q), 32'h77);
    rd(A_SHR, 32'h77, "R4 SHARED readback");
    bus_addr = A_SHR; bus_wdata = 32'h99; bus_wr = 1'b1;
    shr_we = 1'b1; shr_in = 8'h11;
    @(negedge clk);
    bus_wr = 1'b0; shr_we = 1'b0;
    check("R4 hw wins", 32'(shr_q), 32'h11);
    rd(A_SHR, 32'h11, "R4 SHARED after hw load");
    rd(A_CNT, 32'h5, "R5 count of SHARED accesses");

    // R5 wrap and write-ignore
    for (int i = 0; i < 250; i++) rd(A_SHR, 32'h11, "R4 SHARED repeat");
    rd(A_CNT, 32'hFF, "R5 count at all ones");
    rd(A_SHR, 32'h11, "R4 SHARED wrap access");
    rd(A_CNT, 32'h0, "R5 count wrapped");
    wr(A_CNT, 32'h55);
    rd(A_CNT, 32'h0, "R5 counter write ignored");

    // R6 event flag
    evt_set = 1'b1; @(negedge clk); evt_set = 1'b0;
    rd(A_EVT, 32'h1, "R6 flag set");
    rd(A_EVT, 32'h0, "R6 flag cleared by read");
    evt_set = 1'b1; @(negedge clk); evt_set = 1'b0;
    rd(A_STAT, 32'hA7, "R3 STAT between event reads");
    wr(A_EVT, 32'h0);
    rd(A_EVT, 32'h1, "R6 other access and write keep flag");
    evt_set = 1'b1; @(negedge clk); evt_set = 1'b0;
    evt_set = 1'b1;
    rd(A_EVT, 32'h1, "R6 read with set returns old");
    evt_set = 1'b0;
    rd(A_EVT, 32'h1, "R6 set wins over clear");
    rd(A_EVT, 32'h0, "R6 cleared afterwards");

    // R7 array stride
    for (int n = 0; n < 16; n++) wr(A_ARR + 16'(n * 16), 32'hDEAD_0000 | 32'(n * 16'h1111));
    for (int n = 0; n < 16; n++) rd(A_ARR + 16'(n * 16), 32'(n * 16'h1111), "R7 array entry");

    // R8 unmapped
    wr(16'h1004, 32'h1234);
    rd(16'h1004, 32'h0, "R8 hole inside stride");
    rd(A_ARR, 32'h0, "R8 entry 0 untouched by hole write");
    rd(16'h1100, 32'h0, "R8 past array end");
    rd(16'h0FF0, 32'h0, "R8 below array");
    wr(16'h0014, 32'hFFFF_FFFF);
    rd(16'h0014, 32'h0, "R8 unmapped low");
    rd(A_CTRL, 32'h00010025, "R8 CTRL unchanged");

    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'h0);
    check("R9 rvalid idle at end", 32'(bus_rvalid), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule